// File: doc/BRIEF.md
# Double-Buffered SPI Slave

This block is an 8-bit SPI slave for a chip that runs from a fast system clock. An external master drives the serial clock, the active-low select and the data input. All three pass through two-flop synchronisers, and every edge is found in the system clock domain. The slave works in mode 0 with the most significant bit first. It samples the incoming bit on each rising serial clock edge and moves the outgoing bit on each falling edge.

Each direction has a holding register in front of its shifter. Local logic offers the next outgoing byte on a valid/ready write port. `tx_ready` high means the holding register is free. A byte offered while `tx_ready` is low is not taken, and the producer keeps `tx_valid` and `tx_data` steady until a cycle with `tx_ready` high. Each completed incoming byte is placed on a valid/ready read port. `rx_data` stays put while `rx_valid` is high, and a cycle with both `rx_valid` and `rx_ready` high consumes it. The serial master cannot be held off. If a new byte completes before the last one was consumed, the new byte replaces it and a sticky overrun flag is raised. If the shifter needs a byte and none was written, the last byte is sent again and an underrun flag is raised.

The system clock must run at least four times faster than the serial clock. The outgoing data pin is only meant to be driven onto the bus while `miso_oe` is high.

Top module: `spi_slave_dbuf`

## Requirements
- R1: After reset, `tx_ready` is 1. `rx_valid`, `miso_oe`, `underrun` and `overrun` are 0.
- R2: A write is taken only in a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is 0 from the next cycle. A byte offered while `tx_ready` is 0 is ignored and never reaches `miso`.
- R3: When select falls, the held byte moves into the transmit shifter, `tx_ready` goes to 1, and `miso` presents that byte's bit 7.
- R4: Mode 0, MSB first. `mosi` is sampled on each rising serial clock edge. `miso` moves to the next lower bit on each falling edge.
- R5: After the eighth rising edge of a byte, `rx_data` holds the eight sampled bits, with the first bit in bit 7, and `rx_valid` is 1.
- R6: A cycle with `rx_valid` and `rx_ready` both high clears `rx_valid` (and `overrun`) in the next cycle, unless a byte completes in that same cycle.
- R7: On the falling edge that follows the eighth rising edge, the held byte reloads the shifter and `tx_ready` goes to 1. Consecutive bytes under one select therefore carry successive writes.
- R8: A reload that finds `tx_ready` already 1 sends the previous byte again and sets `underrun`. The next accepted write clears `underrun`.
- R9: A byte that completes while `rx_valid` is 1 and is not being read overwrites `rx_data` and sets `overrun`. `overrun` stays set until a read.
- R10: While select is high, `miso_oe` is 0. Select rising in the middle of a byte discards the partial bits: `rx_valid` does not rise, and the next byte under select starts with a fresh count of eight bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master (idles low) |
| ss_n | input | 1 | Active-low slave select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | High while `miso` should drive the bus |
| tx_valid | input | 1 | Outgoing byte offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 8 | Outgoing byte |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Last received byte |
| underrun | output | 1 | A byte was resent because no new byte was written |
| overrun | output | 1 | An unread received byte was overwritten |

## Verification
A change on `sclk`, `ss_n` or `mosi` is acted on at the third system clock edge after it: two edges to synchronise and one to register the result. The port handshakes update their flags at the first edge after the accepting cycle. The bench drives every input at a falling system clock edge. It holds each serial clock level for five system cycles, which leaves two cycles of margin before it samples `miso`. After the last edge of a byte it waits six cycles, then checks `rx_data`, `rx_valid`, `tx_ready` and the flags at a falling system clock edge.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  // Serial-side events, already moved into the system clock domain.
  typedef struct packed {
    logic sel;      // select asserted (synchronised, active high)
    logic rise;     // serial clock rising edge this cycle
    logic fall;     // serial clock falling edge this cycle
    logic ss_fall;  // select has just become active
    logic mosi;     // synchronised serial input, aligned with the edges
  } spi_evt_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync
  import spi_slv_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk,
  input  logic     ss_n,
  input  logic     mosi,
  output spi_evt_t evt
);

  localparam int NSIG = 3;
  // Idle levels: mosi 0, select high (inactive), serial clock low.
  localparam logic [NSIG-1:0] IDLE_V = 3'b010;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] syn;

  assign raw = {mosi, ss_n, sclk};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{IDLE_V[g]}};
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign syn[g] = pipe[STAGES-1];
  end

  logic sclk_q;
  logic ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= syn[0];
      ss_q   <= syn[1];
    end
  end

  assign evt.sel     = ~syn[1];
  assign evt.rise    = syn[0] & ~sclk_q;
  assign evt.fall    = ~syn[0] & sclk_q;
  assign evt.ss_fall = ss_q & ~syn[1];
  assign evt.mosi    = syn[2];

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  spi_evt_t     evt,
  input  logic [W-1:0] tx_hold,
  output logic         tx_load,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  output logic         miso
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  tsh;
  logic [W-2:0]  rsh;
  logic          rx_step;
  logic          tx_step;

  assign rx_step   = evt.sel & evt.rise;
  assign tx_step   = evt.sel & evt.fall;
  assign byte_done = rx_step & (cnt == LAST);
  // Count 0 on a falling edge only happens right after a full byte.
  assign tx_load   = evt.ss_fall | (tx_step & (cnt == '0));
  assign rx_byte   = {rsh, evt.mosi};
  assign miso      = tsh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rsh <= '0;
    end else if (!evt.sel) begin
      cnt <= '0;
    end else if (rx_step) begin
      cnt <= byte_done ? '0 : cnt + 1'b1;
      rsh <= {rsh[W-3:0], evt.mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tsh <= '0;
    else if (tx_load) tsh <= tx_hold;
    else if (tx_step) tsh <= {tsh[W-2:0], 1'b0};
  end

endmodule

// File: rtl/spi_slv_txbuf.sv
module spi_slv_txbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  input  logic         tx_load,
  output logic [W-1:0] tx_hold,
  output logic         underrun
);

  logic empty;
  logic take;

  assign tx_ready = empty;
  assign take     = tx_valid & empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold  <= '0;
      empty    <= 1'b1;
      underrun <= 1'b0;
    end else begin
      if (take) tx_hold <= tx_data;
      // A write in the same cycle as a load wins: the new byte stays held.
      if (take)         empty <= 1'b0;
      else if (tx_load) empty <= 1'b1;
      if (tx_load && empty) underrun <= 1'b1;
      else if (take)        underrun <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_slv_rxbuf.sv
module spi_slv_rxbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_done,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_ready,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         overrun
);

  logic rd;

  assign rd = rx_valid & rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (byte_done) rx_data <= rx_byte;
      if (byte_done) rx_valid <= 1'b1;
      else if (rd)   rx_valid <= 1'b0;
      if (byte_done && rx_valid && !rd) overrun <= 1'b1;
      else if (rd)                      overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_slave_dbuf.sv
module spi_slave_dbuf
  import spi_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              underrun,
  output logic              overrun
);

  spi_evt_t          evt;
  logic              tx_load;
  logic              byte_done;
  logic [DATA_W-1:0] tx_hold;
  logic [DATA_W-1:0] rx_byte;

  spi_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .ss_n  (ss_n),
    .mosi  (mosi),
    .evt   (evt)
  );

  spi_slv_shift #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .tx_hold   (tx_hold),
    .tx_load   (tx_load),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (miso)
  );

  spi_slv_txbuf #(.W(DATA_W)) u_txbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .tx_load  (tx_load),
    .tx_hold  (tx_hold),
    .underrun (underrun)
  );

  spi_slv_rxbuf #(.W(DATA_W)) u_rxbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .rx_ready  (rx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .overrun   (overrun)
  );

  assign miso_oe = evt.sel;

endmodule

// File: rtl/spi_slave_dbuf_chk.sv
module spi_slave_dbuf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic         rx_valid,
  input logic         rx_ready,
  input logic [W-1:0] rx_data,
  input logic         underrun,
  input logic         overrun,
  input logic         tx_load,
  input logic         byte_done
);

  // R2
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  // R2
  tx_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready && !tx_load |=> !tx_ready);

  // R5
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rx_valid);

  // R5
  rx_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rx_data));

  // R6
  rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !byte_done |=> !rx_valid && !overrun);

  // R8
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && tx_ready |=> underrun);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && rx_valid && !rx_ready |=> overrun);

endmodule

bind spi_slave_dbuf spi_slave_dbuf_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .underrun  (underrun),
  .overrun   (overrun),
  .tx_load   (tx_load),
  .byte_done (byte_done)
);

// File: tb/spi_slave_dbuf_tb.sv
module spi_slave_dbuf_tb;

  localparam time CLK_P = 10ns;
  localparam int  HALF  = 5;   // system cycles per serial clock level

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       ss_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic       miso_oe;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       underrun;
  logic       overrun;

  int total = 0;
  int bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  spi_slave_dbuf u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .ss_n     (ss_n),
    .mosi     (mosi),
    .miso     (miso),
    .miso_oe  (miso_oe),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .underrun (underrun),
    .overrun  (overrun)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rx_read();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic sel_on();
    @(negedge clk);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sel_off();
    @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // Mode 0 master: data set at the low level, MISO sampled just before rising.
  task automatic spi_bits(input logic [7:0] mo, input int n, output logic [7:0] mi);
    mi = '0;
    for (int i = 7; i >= 8 - n; i--) begin
      mosi = mo[i];
      repeat (HALF) @(negedge clk);
      mi[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 tx_ready", {7'd0, tx_ready}, 8'h01);
    check("R1 rx_valid", {7'd0, rx_valid}, 8'h00);
    check("R1 miso_oe", {7'd0, miso_oe}, 8'h00);
    check("R1 flags", {6'd0, underrun, overrun}, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] mi;
    tx_write(8'hA5);
    check("R2 ready drops", {7'd0, tx_ready}, 8'h00);
    sel_on();
    check("R3 ready after load", {7'd0, tx_ready}, 8'h01);
    check("R10 miso_oe under select", {7'd0, miso_oe}, 8'h01);
    tx_write(8'h5A);
    spi_bits(8'h3C, 8, mi);
    check("R3 R4 miso byte", mi, 8'hA5);
    check("R5 rx_valid", {7'd0, rx_valid}, 8'h01);
    check("R5 rx_data", rx_data, 8'h3C);
    check("R7 ready after reload", {7'd0, tx_ready}, 8'h01);
    check("R8 no underrun", {7'd0, underrun}, 8'h00);
    rx_read();
    check("R6 rx_valid cleared", {7'd0, rx_valid}, 8'h00);
    sel_off();
    check("R10 miso_oe released", {7'd0, miso_oe}, 8'h00);
  endtask

  task automatic t_stream();
    logic [7:0] mi;
    tx_write(8'h81);
    sel_on();
    tx_write(8'h7E);
    spi_bits(8'h11, 8, mi);
    check("R4 stream byte0", mi, 8'h81);
    check("R5 stream rx0", rx_data, 8'h11);
    rx_read();
    tx_write(8'hC3);
    spi_bits(8'h22, 8, mi);
    check("R7 stream byte1", mi, 8'h7E);
    check("R5 stream rx1", rx_data, 8'h22);
    rx_read();
    sel_off();
    check("R8 stream no underrun", {7'd0, underrun}, 8'h00);
  endtask

  task automatic t_underrun();
    logic [7:0] mi;
    tx_write(8'h96);
    sel_on();
    spi_bits(8'h00, 8, mi);
    check("R4 byte before underrun", mi, 8'h96);
    check("R8 underrun set", {7'd0, underrun}, 8'h01);
    rx_read();
    tx_write(8'h0F);
    check("R8 underrun cleared by write", {7'd0, underrun}, 8'h00);
    spi_bits(8'hFF, 8, mi);
    check("R8 resent byte", mi, 8'h96);
    check("R5 rx after resend", rx_data, 8'hFF);
    check("R8 no new underrun", {7'd0, underrun}, 8'h00);
    rx_read();
    sel_off();
  endtask

  task automatic t_overrun();
    logic [7:0] mi;
    tx_write(8'h44);
    sel_on();
    tx_write(8'h55);
    spi_bits(8'h12, 8, mi);
    check("R9 first rx valid", {7'd0, rx_valid}, 8'h01);
    check("R9 no overrun yet", {7'd0, overrun}, 8'h00);
    tx_write(8'h66);
    spi_bits(8'h34, 8, mi);
    check("R7 second byte out", mi, 8'h55);
    check("R9 rx overwritten", rx_data, 8'h34);
    check("R9 overrun set", {7'd0, overrun}, 8'h01);
    rx_read();
    check("R6 read clears valid", {7'd0, rx_valid}, 8'h00);
    check("R6 read clears overrun", {7'd0, overrun}, 8'h00);
    sel_off();
  endtask

  task automatic t_abort();
    logic [7:0] mi;
    tx_write(8'h77);
    sel_on();
    spi_bits(8'hA0, 4, mi);
    check("R4 partial bits", {4'd0, mi[7:4]}, 8'h07);
    sel_off();
    check("R10 no rx on abort", {7'd0, rx_valid}, 8'h00);
    check("R10 miso_oe after abort", {7'd0, miso_oe}, 8'h00);
    tx_write(8'h99);
    sel_on();
    tx_write(8'h00);
    spi_bits(8'h5C, 8, mi);
    check("R10 fresh count rx", rx_data, 8'h5C);
    check("R10 fresh count tx", mi, 8'h99);
    rx_read();
    sel_off();
  endtask

  task automatic t_ignored();
    logic [7:0] mi;
    tx_write(8'h11);
    tx_write(8'h22);
    check("R2 busy stays", {7'd0, tx_ready}, 8'h00);
    sel_on();
    tx_write(8'h00);
    spi_bits(8'hA0, 8, mi);
    check("R2 ignored write", mi, 8'h11);
    rx_read();
    sel_off();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stream();
    t_underrun();
    t_overrun();
    t_abort();
    t_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule